// File: doc/BRIEF.md
# Interrupt Priority Claim Arbiter

This block keeps, for every interrupt source, a pending flag and an in-service (claimed) flag. It picks the single source that one target context should take next. Each cycle it looks at the source priorities, the context's enable mask and the context's threshold. The best eligible source is registered as the winner ID, and the context's external interrupt line is driven from the same register stage.

Software serves the interrupt in two steps.

- A claim strobe takes the current winner: that source's pending flag drops and its claimed flag rises, so the source drops out of the selection.
- A completion strobe carries a source ID and releases that source's claimed flag.

Request inputs are level sensitive. A high level sets pending. Only a claim ever clears it.

Source ID 0 is reserved and means "nothing to deliver".

Top module: `irq_claim_arbiter`

## Requirements
- R1: While reset is asserted and right after it is released, `win_id` is 0 and `ext_irq` is 0. Reset also clears every pending and claimed flag, so nothing wins until a new request arrives.
- R2: A source can win only if it is pending, its bit in `ctx_enable` is 1, and it is not claimed.
- R3: A source can win only if its priority is strictly greater than `ctx_threshold`. A priority equal to the threshold does not qualify.
- R4: Among eligible sources, the highest priority wins. On equal priority, the lowest source ID wins.
- R5: `ext_irq` is 1 exactly when `win_id` is nonzero.
- R6: A claim while `win_id` is nonzero clears that source's pending flag and sets its claimed flag. The next eligible source then becomes the winner.
- R7: A claim while `win_id` is 0 changes no state.
- R8: A completion with an ID below NUM_SOURCES clears that source's claimed flag. A completion with an ID of NUM_SOURCES or more is ignored.
- R9: A request returning low does not clear a pending flag.
- R10: Source 0 never becomes pending and never wins.
- R11: A claim and a new request for the same source in the same cycle leave that source not pending. The claim wins.
- R12: `win_id` and `ext_irq` reflect a change in requests, priorities, enables, threshold or strobes at the first rising clock edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SOURCES | Level request per source; bit 0 is ignored |
| src_prio | input | NUM_SOURCES*PRIO_W | Priority per source; source i occupies bits [i*PRIO_W +: PRIO_W] |
| ctx_enable | input | NUM_SOURCES | Enable mask of the context |
| ctx_threshold | input | PRIO_W | Context threshold; only priorities above it are delivered |
| claim_req | input | 1 | One-cycle claim of the current winner |
| complete_req | input | 1 | One-cycle completion strobe |
| complete_id | input | $clog2(NUM_SOURCES)+1 | Source ID being completed |
| win_id | output | $clog2(NUM_SOURCES)+1 | Registered winner ID, 0 when none |
| ext_irq | output | 1 | External interrupt line of the context |

## Verification
The bench builds the block with NUM_SOURCES = 40 and PRIO_W = 3, which are also the defaults. With 40 sources the winner can sit above ID 31. The padded tournament then has unused leaves, so a mistake in the padding or in the upper half of the tree becomes visible.

An ID width of 7 bits means completion IDs of 40 and above can actually be driven. That makes the out-of-range case testable at its exact boundary.

Three priority bits leave room for three cases to sit side by side:
- a threshold equal to a priority,
- two sources tied at one level,
- a lower-priority source waiting behind them.

// File: rtl/irq_arb_pkg.sv
`timescale 1ns/1ps
package irq_arb_pkg;

  // Decides whether the right-hand entrant of a tournament node replaces the
  // left-hand one. The left side always carries the lower IDs, so only a
  // strictly higher priority displaces it; ties stay with the lower ID.
  function automatic logic right_takes(input logic        l_vld,
                                       input logic [31:0] l_prio,
                                       input logic        r_vld,
                                       input logic [31:0] r_prio);
    return r_vld && (!l_vld || (r_prio > l_prio));
  endfunction

endpackage

// File: rtl/irq_src_state.sv
`timescale 1ns/1ps
module irq_src_state #(
  parameter int NUM_SOURCES = 40,
  parameter int ID_W        = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SOURCES-1:0] req,
  input  logic                   take_go,
  input  logic [ID_W-1:0]        take_id,
  input  logic                   done_go,
  input  logic [ID_W-1:0]        done_id,
  output logic [NUM_SOURCES-1:0] pend_nxt,
  output logic [NUM_SOURCES-1:0] busy_nxt
);

  logic [NUM_SOURCES-1:0] pend_q, busy_q;
  logic [NUM_SOURCES-1:0] take_mask, done_mask;
  logic                   upd_en;

  // one-hot decode of the claim and completion IDs; IDs at or above
  // NUM_SOURCES match no bit and so have no effect
  for (genvar i = 0; i < NUM_SOURCES; i++) begin : g_dec
    assign take_mask[i] = take_go && (take_id == ID_W'(i));
    assign done_mask[i] = done_go && (done_id == ID_W'(i));
  end

  always_comb begin
    // source 0 is reserved and never latches a request
    pend_nxt    = (pend_q | req) & ~take_mask;
    pend_nxt[0] = 1'b0;
    // a claim of the same ID overrides a completion
    busy_nxt    = (busy_q & ~done_mask) | take_mask;
    upd_en      = (|req[NUM_SOURCES-1:1]) | take_go | done_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      busy_q <= '0;
    end else if (upd_en) begin
      pend_q <= pend_nxt;
      busy_q <= busy_nxt;
    end
  end

endmodule

// File: rtl/irq_prio_tournament.sv
`timescale 1ns/1ps
module irq_prio_tournament
  import irq_arb_pkg::*;
#(
  parameter int NUM_SOURCES = 40,
  parameter int PRIO_W      = 3,
  parameter int ID_W        = 7
) (
  input  logic [NUM_SOURCES-1:0]        cand,
  input  logic [NUM_SOURCES*PRIO_W-1:0] prio,
  output logic [ID_W-1:0]               best_id
);

  localparam int LVL    = (NUM_SOURCES > 1) ? $clog2(NUM_SOURCES) : 1;
  localparam int LEAVES = 1 << LVL;

  // heap layout: node n has children 2n and 2n+1, leaves start at LEAVES
  logic              nd_v [2*LEAVES];
  logic [PRIO_W-1:0] nd_p [2*LEAVES];
  logic [ID_W-1:0]   nd_i [2*LEAVES];

  assign nd_v[0] = 1'b0;
  assign nd_p[0] = '0;
  assign nd_i[0] = '0;

  // leaves past NUM_SOURCES are padding and never qualify
  for (genvar l = 0; l < LEAVES; l++) begin : g_leaf
    if (l < NUM_SOURCES) begin : g_real
      assign nd_v[LEAVES+l] = cand[l];
      assign nd_p[LEAVES+l] = prio[l*PRIO_W +: PRIO_W];
      assign nd_i[LEAVES+l] = ID_W'(l);
    end else begin : g_pad
      assign nd_v[LEAVES+l] = 1'b0;
      assign nd_p[LEAVES+l] = '0;
      assign nd_i[LEAVES+l] = '0;
    end
  end

  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic pick_r;
    assign pick_r  = right_takes(nd_v[2*n],   32'(nd_p[2*n]),
                                 nd_v[2*n+1], 32'(nd_p[2*n+1]));
    assign nd_v[n] = nd_v[2*n] | nd_v[2*n+1];
    assign nd_p[n] = pick_r ? nd_p[2*n+1] : nd_p[2*n];
    assign nd_i[n] = pick_r ? nd_i[2*n+1] : nd_i[2*n];
  end

  assign best_id = nd_v[1] ? nd_i[1] : '0;

endmodule

// File: rtl/irq_claim_arbiter.sv
`timescale 1ns/1ps
module irq_claim_arbiter #(
  parameter int NUM_SOURCES = 40,
  parameter int PRIO_W      = 3,
  localparam int ID_W       = $clog2(NUM_SOURCES) + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_SOURCES-1:0]        src_req,
  input  logic [NUM_SOURCES*PRIO_W-1:0] src_prio,
  input  logic [NUM_SOURCES-1:0]        ctx_enable,
  input  logic [PRIO_W-1:0]             ctx_threshold,
  input  logic                          claim_req,
  input  logic                          complete_req,
  input  logic [ID_W-1:0]               complete_id,
  output logic [ID_W-1:0]               win_id,
  output logic                          ext_irq
);

  logic [NUM_SOURCES-1:0] pend_nxt, busy_nxt, cand;
  logic [ID_W-1:0]        best_id;
  logic [ID_W-1:0]        win_q, win_d;
  logic                   irq_q, irq_d;
  logic                   take_go;

  // a claim only acts when a winner is being presented
  assign take_go = claim_req && (win_q != '0);

  irq_src_state #(
    .NUM_SOURCES (NUM_SOURCES),
    .ID_W        (ID_W)
  ) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (src_req),
    .take_go  (take_go),
    .take_id  (win_q),
    .done_go  (complete_req),
    .done_id  (complete_id),
    .pend_nxt (pend_nxt),
    .busy_nxt (busy_nxt)
  );

  // eligibility is judged on the post-edge flags so the registered winner
  // never points at a source that the same edge has just claimed
  for (genvar i = 0; i < NUM_SOURCES; i++) begin : g_cand
    if (i == 0) begin : g_rsv
      assign cand[i] = 1'b0;
    end else begin : g_src
      assign cand[i] = pend_nxt[i] & ~busy_nxt[i] & ctx_enable[i] &
                       (src_prio[i*PRIO_W +: PRIO_W] > ctx_threshold);
    end
  end

  irq_prio_tournament #(
    .NUM_SOURCES (NUM_SOURCES),
    .PRIO_W      (PRIO_W),
    .ID_W        (ID_W)
  ) u_tourn (
    .cand    (cand),
    .prio    (src_prio),
    .best_id (best_id)
  );

  always_comb begin
    win_d = best_id;
    irq_d = (best_id != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      irq_q <= 1'b0;
    end else begin
      win_q <= win_d;
      irq_q <= irq_d;
    end
  end

  assign win_id  = win_q;
  assign ext_irq = irq_q;

endmodule

// File: rtl/irq_arb_checker.sv
`timescale 1ns/1ps
module irq_arb_checker #(
  parameter int NUM_SOURCES = 40,
  parameter int PRIO_W      = 3,
  localparam int ID_W       = $clog2(NUM_SOURCES) + 1,
  localparam int IDX_W      = $clog2(NUM_SOURCES)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_SOURCES*PRIO_W-1:0] src_prio,
  input logic [NUM_SOURCES-1:0]        ctx_enable,
  input logic [PRIO_W-1:0]             ctx_threshold,
  input logic                          claim_req,
  input logic [ID_W-1:0]               win_id,
  input logic                          ext_irq
);

  logic [NUM_SOURCES-1:0]        en_p;
  logic [NUM_SOURCES*PRIO_W-1:0] prio_p;
  logic [PRIO_W-1:0]             thr_p;
  logic [IDX_W-1:0]              w_idx;

  // copies of the inputs the winner was computed from
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_p   <= '0;
      prio_p <= '0;
      thr_p  <= '0;
    end else begin
      en_p   <= ctx_enable;
      prio_p <= src_prio;
      thr_p  <= ctx_threshold;
    end
  end

  assign w_idx = win_id[IDX_W-1:0];

  AST_IRQ_MATCHES_ID: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq == (win_id != '0)); // R5

  AST_ID_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    win_id < ID_W'(NUM_SOURCES)); // R10

  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != '0) |-> en_p[w_idx]); // R2

  AST_ABOVE_THRESHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != '0) |-> (prio_p[int'(w_idx)*PRIO_W +: PRIO_W] > thr_p)); // R3

  AST_CLAIM_MOVES_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_req && (win_id != '0)) |=> (win_id != $past(win_id))); // R6

endmodule

bind irq_claim_arbiter irq_arb_checker #(
  .NUM_SOURCES (NUM_SOURCES),
  .PRIO_W      (PRIO_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .src_prio      (src_prio),
  .ctx_enable    (ctx_enable),
  .ctx_threshold (ctx_threshold),
  .claim_req     (claim_req),
  .win_id        (win_id),
  .ext_irq       (ext_irq)
);

// File: tb/irq_claim_arbiter_bench.sv
`timescale 1ns/1ps
module irq_claim_arbiter_bench;

  localparam int NS = 40;
  localparam int PW = 3;
  localparam int IW = $clog2(NS) + 1;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   src_req;
  logic [NS*PW-1:0] src_prio;
  logic [NS-1:0]   ctx_enable;
  logic [PW-1:0]   ctx_threshold;
  logic            claim_req;
  logic            complete_req;
  logic [IW-1:0]   complete_id;
  logic [IW-1:0]   win_id;
  logic            ext_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  irq_claim_arbiter #(.NUM_SOURCES(NS), .PRIO_W(PW)) u_irq_claim_arbiter (
    .clk           (clk),
    .rst_n         (rst_n),
    .src_req       (src_req),
    .src_prio      (src_prio),
    .ctx_enable    (ctx_enable),
    .ctx_threshold (ctx_threshold),
    .claim_req     (claim_req),
    .complete_req  (complete_req),
    .complete_id   (complete_id),
    .win_id        (win_id),
    .ext_irq       (ext_irq)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    src_req = '0; src_prio = '0; ctx_enable = '0; ctx_threshold = '0;
    claim_req = 1'b0; complete_req = 1'b0; complete_id = '0;
    repeat (2) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic set_prio(input int s, input int p);
    src_prio[s*PW +: PW] = PW'(p);
  endtask

  task automatic pulse_req(input int s);
    src_req[s] = 1'b1;
    step();
    src_req[s] = 1'b0;
  endtask

  task automatic do_claim();
    claim_req = 1'b1;
    step();
    claim_req = 1'b0;
  endtask

  task automatic do_complete(input int id);
    complete_id  = IW'(id);
    complete_req = 1'b1;
    step();
    complete_req = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 win after reset", int'(win_id), 0);
    chk("R1 irq after reset", int'(ext_irq), 0);
    ctx_enable[2] = 1'b1; set_prio(2, 4);
    pulse_req(2);
    chk("R1 pre-reset winner", int'(win_id), 2);
    rst_n = 1'b0;
    step();
    chk("R1 win during reset", int'(win_id), 0);
    chk("R1 irq during reset", int'(ext_irq), 0);
    rst_n = 1'b1;
    step(); step();
    chk("R1 pending cleared by reset", int'(win_id), 0);
  endtask

  task automatic t_threshold();
    do_reset();
    set_prio(5, 3); ctx_enable[5] = 1'b1; ctx_threshold = 3'd3;
    pulse_req(5);
    chk("R3 equal to threshold", int'(win_id), 0);
    chk("R5 irq low with no winner", int'(ext_irq), 0);
    step();
    chk("R9 pending kept after request low", int'(win_id), 0);
    ctx_threshold = 3'd2;
    step();
    chk("R12 winner one edge after threshold", int'(win_id), 5);
    chk("R5 irq high with winner", int'(ext_irq), 1);
    do_claim();
    chk("R6 claimed source leaves", int'(win_id), 0);
    do_complete(5);
    chk("R6 pending was cleared by claim", int'(win_id), 0);
  endtask

  task automatic t_enable();
    do_reset();
    set_prio(7, 4);
    pulse_req(7);
    chk("R2 disabled source", int'(win_id), 0);
    ctx_enable[7] = 1'b1;
    step();
    chk("R2 enabled source", int'(win_id), 7);
    do_claim();
    pulse_req(7);
    chk("R2 claimed source masked", int'(win_id), 0);
    do_complete(7);
    chk("R8 complete unmasks", int'(win_id), 7);
  endtask

  task automatic t_order();
    do_reset();
    set_prio(3, 2); set_prio(9, 6); set_prio(35, 6);
    ctx_enable = '1;
    src_req[3] = 1'b1; src_req[9] = 1'b1; src_req[35] = 1'b1;
    step();
    src_req = '0;
    chk("R4 tie to lowest id", int'(win_id), 9);
    do_claim();
    chk("R4 next equal priority", int'(win_id), 35);
    do_claim();
    chk("R4 lower priority last", int'(win_id), 3);
    do_claim();
    chk("R6 all claimed", int'(win_id), 0);
    do_complete(9);
    chk("R8 complete without pending", int'(win_id), 0);
  endtask

  task automatic t_empty_claim();
    do_reset();
    set_prio(12, 1); ctx_enable[12] = 1'b1; ctx_threshold = 3'd5;
    pulse_req(12);
    chk("R3 below threshold", int'(win_id), 0);
    do_claim();
    chk("R7 empty claim", int'(win_id), 0);
    ctx_threshold = 3'd0;
    step();
    chk("R7 pending survived empty claim", int'(win_id), 12);
  endtask

  task automatic t_complete_range();
    do_reset();
    set_prio(33, 5); ctx_enable[33] = 1'b1;
    pulse_req(33);
    chk("R4 upper source wins", int'(win_id), 33);
    do_claim();
    pulse_req(33);
    chk("R8 claimed masked", int'(win_id), 0);
    do_complete(40);
    chk("R8 complete id 40 ignored", int'(win_id), 0);
    do_complete(41);
    chk("R8 complete id 41 ignored", int'(win_id), 0);
    do_complete(33);
    chk("R8 complete in range", int'(win_id), 33);
  endtask

  task automatic t_src0();
    do_reset();
    set_prio(0, 7); ctx_enable[0] = 1'b1;
    pulse_req(0);
    chk("R10 source 0 never wins", int'(win_id), 0);
    set_prio(1, 1); ctx_enable[1] = 1'b1;
    pulse_req(1);
    chk("R10 source 1 wins over source 0", int'(win_id), 1);
  endtask

  task automatic t_collision();
    do_reset();
    set_prio(20, 7); ctx_enable[20] = 1'b1;
    pulse_req(20);
    chk("R11 setup winner", int'(win_id), 20);
    claim_req = 1'b1; src_req[20] = 1'b1;
    step();
    claim_req = 1'b0; src_req[20] = 1'b0;
    chk("R11 claim with same-cycle request", int'(win_id), 0);
    do_complete(20);
    chk("R11 pending stays cleared", int'(win_id), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_threshold();
    t_enable();
    t_order();
    t_empty_claim();
    t_complete_range();
    t_src0();
    t_collision();
    finish_run();
  end

endmodule